// File: doc/BRIEF.md
# Framed Front-Panel Command Receiver

This block sits on the front-panel side of a serial link from a host controller. It deserializes an asynchronous 8N1 line (idle high, low start bit, high stop bit, least significant bit first) with a 16x oversampling receiver, then assembles the received bytes into typed, length-prefixed frames protected by an XOR checksum. A valid lamp frame latches three indicator outputs. A valid text frame replays its characters to a display writer as a one-cycle-per-character stream.

A frame is a kind byte, a count byte holding the payload length plus one, the payload, and a checksum byte. The checksum equals the XOR of the kind byte, the count byte and every payload byte. Bad checksums, unknown kinds, illegal counts, broken stop bits and long gaps inside a frame each raise a one-cycle error pulse. Bit timing and the gap limit are parameters in clock cycles. `TICK_DIV` clocks make one oversample tick, and `GAP_CYCLES` is set to the cycle count of 10 ms at the system clock.

Top module: `panel_cmd_rx`

## Requirements
- R1: While reset is held and right after its release, `led_n` is 3'b111 (all lamps off), and `frame_ok`, `frame_err`, `char_valid` and `char_last` are 0.
- R2: Bytes are received as 8N1, least significant bit first, with the start bit confirmed at its middle. A low pulse shorter than half a bit starts no byte and produces no pulse.
- R3: A byte whose stop bit samples low while a frame is in progress raises `frame_err` and abandons that frame. The next kind byte starts a fresh frame.
- R4: A frame is kind, count (payload length N plus one), N payload bytes, and checksum. When the checksum byte equals the XOR of all earlier bytes of the frame, `frame_ok` pulses for one cycle.
- R5: A checksum mismatch pulses `frame_err`, leaves `led_n` unchanged and emits no characters.
- R6: Kind 8'hA4 is a lamp frame with exactly one payload byte. On its `frame_ok` cycle, `led_n[0]` becomes the inverse of payload bit 0 (answer lamp), `led_n[1]` the inverse of bit 1 (ink-save lamp) and `led_n[2]` the inverse of bit 2 (silent lamp). Bits 7..3 are ignored, and `led_n` changes in no other cycle.
- R7: Kind 8'hA1 is a text frame with 0 to LINE_MAX characters. After its `frame_ok` pulse, the characters appear on `char_data` with `char_valid` high, one per cycle in arrival order, starting the next cycle. `char_last` marks the final one. A text frame with count 1 gives `frame_ok` and no characters.
- R8: An unknown kind byte, a zero count, a lamp count other than 2, or a text count above LINE_MAX+1 pulses `frame_err` once. All following bytes are then dropped until the line has been quiet for GAP_CYCLES, after which a new kind byte is accepted.
- R9: If the line stays quiet for GAP_CYCLES while the count, a payload byte or the checksum is awaited, `frame_err` pulses and the parser returns to waiting for a kind byte.
- R10: `frame_ok` and `frame_err` are one-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial input, idle high |
| led_n | output | 3 | Active-low lamps: [0] answer, [1] ink-save, [2] silent |
| char_valid | output | 1 | A text character is on `char_data` this cycle |
| char_data | output | 8 | ASCII character |
| char_last | output | 1 | Final character of the line |
| frame_ok | output | 1 | One-cycle pulse: frame accepted |
| frame_err | output | 1 | One-cycle pulse: frame rejected or aborted |

## Verification
A wrong parser state mostly shows up as a missing or extra `frame_ok`/`frame_err` pulse within one bit time of the checksum or offending byte. A lost discard state shows up as an accepted frame that should have been dropped. A bad checksum accumulator or payload index shows up in the character stream at most LINE_MAX cycles after the accept pulse, as wrong or reordered characters. The lamp outputs are watched on every clock, so any change outside an accept pulse is flagged in the cycle it happens. A faulty gap timer appears either as a missing timeout error after GAP_CYCLES or as valid frames rejected after the discard window.

// File: rtl/panel_rx_pkg.sv
package panel_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef enum logic [2:0] {
        PS_KIND,
        PS_COUNT,
        PS_DATA,
        PS_SUM,
        PS_SKIP
    } parse_state_e;

    localparam logic [7:0] KIND_TEXT = 8'hA1;
    localparam logic [7:0] KIND_LAMP = 8'hA4;

endpackage

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import panel_rx_pkg::*;
#(
    parameter int TICK_DIV = 4,
    parameter int OSR      = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_line,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       stop_bad,
    output logic       busy
);

    localparam int DW   = $clog2(TICK_DIV);
    localparam int SW   = $clog2(OSR);
    localparam int HALF = OSR / 2 - 1;

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [DW-1:0] div;
        rx_state_e     st;
        logic [SW-1:0] ph;
        logic [2:0]    nbit;
        logic [7:0]    sh;
        logic          vld;
        logic          bad;
    } rx_regs_t;

    rx_regs_t q, d;
    logic     tick;

    always_comb begin
        d      = q;
        d.s1   = rx_line;
        d.s2   = q.s1;
        d.vld  = 1'b0;
        d.bad  = 1'b0;
        tick   = (q.div == DW'(TICK_DIV - 1));
        d.div  = tick ? '0 : q.div + 1'b1;
        if (tick) begin
            unique case (q.st)
                RX_IDLE: begin
                    if (!q.s2) begin
                        d.st = RX_START;
                        d.ph = '0;
                    end
                end
                RX_START: begin
                    if (q.ph == SW'(HALF)) begin
                        d.ph = '0;
                        if (!q.s2) begin
                            d.st   = RX_DATA;
                            d.nbit = '0;
                        end else begin
                            d.st = RX_IDLE;
                        end
                    end else begin
                        d.ph = q.ph + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (q.ph == SW'(OSR - 1)) begin
                        d.ph   = '0;
                        d.sh   = {q.s2, q.sh[7:1]};
                        d.nbit = q.nbit + 1'b1;
                        if (q.nbit == 3'd7) d.st = RX_STOP;
                    end else begin
                        d.ph = q.ph + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (q.ph == SW'(OSR - 1)) begin
                        d.ph  = '0;
                        d.st  = RX_IDLE;
                        d.vld = q.s2;
                        d.bad = !q.s2;
                    end else begin
                        d.ph = q.ph + 1'b1;
                    end
                end
                default: d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.s1   <= 1'b1;
            q.s2   <= 1'b1;
            q.st   <= RX_IDLE;
        end else begin
            q <= d;
        end
    end

    assign byte_valid = q.vld;
    assign byte_data  = q.sh;
    assign stop_bad   = q.bad;
    assign busy       = (q.st != RX_IDLE);

    // R3: a stop-bit fault can only follow the stop-bit phase
    a_r3_bad_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        q.bad |-> $past(q.st == RX_STOP));

    // R2: a byte is either delivered or reported bad, never both
    a_r2_result_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.vld && q.bad));

endmodule

// File: rtl/line_gap_timer.sv
module line_gap_timer #(
    parameter int GAP_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    output logic expired
);

    localparam int GW = $clog2(GAP_CYCLES + 1);

    typedef struct packed {
        logic [GW-1:0] cnt;
    } gap_regs_t;

    gap_regs_t q, d;

    always_comb begin
        d = q;
        if (busy) begin
            d.cnt = '0;
        end else if (q.cnt != GW'(GAP_CYCLES)) begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign expired = (q.cnt == GW'(GAP_CYCLES));

    // R9: once the quiet limit is reached it holds while the line stays quiet
    a_r9_gap_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !busy) |=> expired);

endmodule

// File: rtl/frame_parser.sv
module frame_parser
    import panel_rx_pkg::*;
#(
    parameter int LINE_MAX = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       stop_bad,
    input  logic       gap_expired,
    output logic [2:0] led_n,
    output logic       char_valid,
    output logic [7:0] char_data,
    output logic       char_last,
    output logic       frame_ok,
    output logic       frame_err
);

    localparam int IW = $clog2(LINE_MAX);
    localparam int LW = $clog2(LINE_MAX + 1);

    typedef struct packed {
        parse_state_e              st;
        logic                      is_text;
        logic [7:0]                left;
        logic [LW-1:0]             len;
        logic [IW-1:0]             wr;
        logic [7:0]                acc;
        logic [LINE_MAX-1:0][7:0]  line;
        logic [2:0]                lamp;
        logic [2:0]                led_n;
        logic                      streaming;
        logic [IW-1:0]             rd;
        logic [LW-1:0]             olen;
        logic                      cv;
        logic [7:0]                cd;
        logic                      cl;
        logic                      ok;
        logic                      err;
    } parse_regs_t;

    parse_regs_t q, d;
    logic        in_frame;

    assign in_frame = (q.st == PS_COUNT) || (q.st == PS_DATA) || (q.st == PS_SUM);

    always_comb begin
        d     = q;
        d.ok  = 1'b0;
        d.err = 1'b0;
        d.cv  = 1'b0;
        d.cl  = 1'b0;

        // character replay, one per cycle
        if (q.streaming) begin
            d.cv = 1'b1;
            d.cd = q.line[q.rd];
            d.rd = q.rd + 1'b1;
            if ((LW'(q.rd) + LW'(1)) == q.olen) begin
                d.cl        = 1'b1;
                d.streaming = 1'b0;
            end
        end

        if (stop_bad && in_frame) begin
            d.err = 1'b1;
            d.st  = PS_KIND;
        end else if (gap_expired && in_frame) begin
            d.err = 1'b1;
            d.st  = PS_KIND;
        end else if (gap_expired && q.st == PS_SKIP) begin
            d.st = PS_KIND;
        end else if (byte_valid) begin
            unique case (q.st)
                PS_KIND: begin
                    d.acc = byte_data;
                    if (byte_data == KIND_TEXT) begin
                        d.is_text = 1'b1;
                        d.st      = PS_COUNT;
                    end else if (byte_data == KIND_LAMP) begin
                        d.is_text = 1'b0;
                        d.st      = PS_COUNT;
                    end else begin
                        d.err = 1'b1;
                        d.st  = PS_SKIP;
                    end
                end
                PS_COUNT: begin
                    d.acc = q.acc ^ byte_data;
                    if (byte_data == 8'd0 ||
                        (!q.is_text && byte_data != 8'd2) ||
                        (q.is_text && byte_data > 8'(LINE_MAX + 1))) begin
                        d.err = 1'b1;
                        d.st  = PS_SKIP;
                    end else begin
                        d.left = byte_data - 8'd1;
                        d.len  = LW'(byte_data - 8'd1);
                        d.wr   = '0;
                        d.st   = (byte_data == 8'd1) ? PS_SUM : PS_DATA;
                    end
                end
                PS_DATA: begin
                    d.acc  = q.acc ^ byte_data;
                    d.left = q.left - 8'd1;
                    if (q.is_text) begin
                        d.line[q.wr] = byte_data;
                        d.wr         = q.wr + 1'b1;
                    end else begin
                        d.lamp = byte_data[2:0];
                    end
                    if (q.left == 8'd1) d.st = PS_SUM;
                end
                PS_SUM: begin
                    d.st = PS_KIND;
                    if (byte_data == q.acc) begin
                        d.ok = 1'b1;
                        if (!q.is_text) begin
                            d.led_n = ~q.lamp;
                        end else if (q.len != '0) begin
                            d.streaming = 1'b1;
                            d.rd        = '0;
                            d.olen      = q.len;
                        end
                    end else begin
                        d.err = 1'b1;
                    end
                end
                PS_SKIP: d.st = PS_SKIP;
                default: d.st = PS_KIND;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= PS_KIND;
            q.led_n <= 3'b111;
        end else begin
            q <= d;
        end
    end

    assign led_n      = q.led_n;
    assign char_valid = q.cv;
    assign char_data  = q.cd;
    assign char_last  = q.cl;
    assign frame_ok   = q.ok;
    assign frame_err  = q.err;

    // R6: lamps move only together with an accept pulse
    a_r6_lamp_moves_on_ok: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.led_n) |-> q.ok);

    // R10: accept and reject never coincide
    a_r10_ok_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.ok && q.err));

    // R7: a non-empty accepted text frame starts its replay next cycle
    a_r7_replay_follows_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ok && q.is_text && q.len != '0) |=> q.cv);

    // R7: the end marker only rides on a character
    a_r7_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        q.cl |-> q.cv);

    // R9: quiet line inside a frame produces a reject next cycle
    a_r9_timeout_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_expired && in_frame) |=> q.err);

endmodule

// File: rtl/panel_cmd_rx.sv
module panel_cmd_rx #(
    parameter int TICK_DIV   = 4,
    parameter int OSR        = 16,
    parameter int GAP_CYCLES = 2000,
    parameter int LINE_MAX   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_line,
    output logic [2:0] led_n,
    output logic       char_valid,
    output logic [7:0] char_data,
    output logic       char_last,
    output logic       frame_ok,
    output logic       frame_err
);

    logic       byte_valid;
    logic [7:0] byte_data;
    logic       stop_bad;
    logic       rx_busy;
    logic       gap_expired;

    uart_os_rx #(
        .TICK_DIV (TICK_DIV),
        .OSR      (OSR)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_line    (rx_line),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .stop_bad   (stop_bad),
        .busy       (rx_busy)
    );

    line_gap_timer #(
        .GAP_CYCLES (GAP_CYCLES)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (rx_busy),
        .expired (gap_expired)
    );

    frame_parser #(
        .LINE_MAX (LINE_MAX)
    ) u_parse (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .stop_bad    (stop_bad),
        .gap_expired (gap_expired),
        .led_n       (led_n),
        .char_valid  (char_valid),
        .char_data   (char_data),
        .char_last   (char_last),
        .frame_ok    (frame_ok),
        .frame_err   (frame_err)
    );

endmodule

// File: tb/panel_cmd_rx_tb_top.sv
module panel_cmd_rx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int OSR        = 16;
    localparam int GAP        = 2000;
    localparam int LINE       = 16;
    localparam int BIT        = TICK_DIV * OSR;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic [2:0] led_n;
    logic       char_valid;
    logic [7:0] char_data;
    logic       char_last;
    logic       frame_ok;
    logic       frame_err;

    always #(CLK_PERIOD / 2) clk = ~clk;

    panel_cmd_rx #(
        .TICK_DIV   (TICK_DIV),
        .OSR        (OSR),
        .GAP_CYCLES (GAP),
        .LINE_MAX   (LINE)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_line    (rx),
        .led_n      (led_n),
        .char_valid (char_valid),
        .char_data  (char_data),
        .char_last  (char_last),
        .frame_ok   (frame_ok),
        .frame_err  (frame_err)
    );

    int checks = 0;
    int errors = 0;
    int ok_cnt = 0;
    int err_cnt = 0;
    int last_marks = 0;
    int last_idx = -1;
    logic [7:0] chars[$];
    logic [7:0] pay[$];
    logic [2:0] led_prev = 3'b111;
    logic [2:0] led_exp = 3'b111;

    // per-clock reference comparison of lamps and pulse rules
    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_ok) ok_cnt++;
            if (frame_err) err_cnt++;
            if (char_valid) begin
                chars.push_back(char_data);
                if (char_last) begin
                    last_marks++;
                    last_idx = chars.size() - 1;
                end
            end
            if (led_n !== led_prev && !frame_ok) begin
                checks++; errors++;
                $display("FAIL R6: lamps changed without accept, actual %b expected %b", led_n, led_prev);
            end
            if (frame_ok && frame_err) begin
                checks++; errors++;
                $display("FAIL R10: ok and err together, actual 1 expected 0");
            end
            led_prev = led_n;
        end
    end

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit good_stop);
        @(negedge clk);
        rx = 1'b0;
        idle(BIT);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            idle(BIT);
        end
        rx = good_stop;
        idle(BIT);
        rx = 1'b1;
    endtask

    // sends kind, count, pay, checksum (optionally corrupted)
    task automatic send_frame(input logic [7:0] kind, input logic [7:0] cnt, input bit corrupt);
        logic [7:0] x;
        x = kind ^ cnt;
        send_byte(kind, 1'b1);
        send_byte(cnt, 1'b1);
        foreach (pay[i]) begin
            x = x ^ pay[i];
            send_byte(pay[i], 1'b1);
        end
        send_byte(corrupt ? (x ^ 8'h5A) : x, 1'b1);
        idle(4 * BIT);
    endtask

    task automatic lamp_frame(input logic [7:0] v, input bit corrupt);
        pay.delete();
        pay.push_back(v);
        send_frame(8'hA4, 8'd2, corrupt);
    endtask

    initial begin : watchdog
        idle(190000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        int ok0, er0;
        // R1 reset state
        idle(5);
        check(led_n == 3'b111, "R1 lamps off in reset", led_n, 7);
        check(!frame_ok && !frame_err, "R1 no pulses in reset", frame_ok + frame_err, 0);
        check(!char_valid && !char_last, "R1 no chars in reset", char_valid, 0);
        rst_n = 1'b1;
        idle(4 * BIT);
        check(led_n == 3'b111, "R1 lamps off after reset", led_n, 7);

        // R4/R6 lamp frame, upper bits ignored
        ok0 = ok_cnt; er0 = err_cnt;
        lamp_frame(8'hF5, 1'b0);
        led_exp = 3'b010;
        check(ok_cnt == ok0 + 1, "R4 accept pulse", ok_cnt - ok0, 1);
        check(err_cnt == er0, "R4 no reject", err_cnt - er0, 0);
        check(led_n == led_exp, "R6 lamps from F5", led_n, led_exp);

        lamp_frame(8'h02, 1'b0);
        led_exp = 3'b101;
        check(led_n == led_exp, "R6 lamps from 02", led_n, led_exp);

        // R7 text frame
        chars.delete(); last_marks = 0; last_idx = -1;
        pay.delete(); pay.push_back(8'h48); pay.push_back(8'h49); pay.push_back(8'h21);
        send_frame(8'hA1, 8'd4, 1'b0);
        check(chars.size() == 3, "R7 char count", chars.size(), 3);
        if (chars.size() == 3)
            check(chars[0] == 8'h48 && chars[1] == 8'h49 && chars[2] == 8'h21,
                  "R7 char order", chars[0], 8'h48);
        check(last_marks == 1 && last_idx == 2, "R7 last marker", last_idx, 2);

        // R5 checksum mismatch
        ok0 = ok_cnt; er0 = err_cnt;
        lamp_frame(8'h07, 1'b1);
        check(err_cnt == er0 + 1 && ok_cnt == ok0, "R5 lamp bad sum rejected", err_cnt - er0, 1);
        check(led_n == led_exp, "R5 lamps unchanged", led_n, led_exp);
        chars.delete();
        pay.delete(); pay.push_back(8'h5A);
        send_frame(8'hA1, 8'd2, 1'b1);
        check(chars.size() == 0, "R5 no chars on bad sum", chars.size(), 0);

        // R8 unknown kind then discarded traffic
        ok0 = ok_cnt; er0 = err_cnt;
        send_byte(8'h55, 1'b1);
        lamp_frame(8'h07, 1'b0);
        check(err_cnt == er0 + 1 && ok_cnt == ok0, "R8 unknown kind discards", ok_cnt - ok0, 0);
        check(led_n == led_exp, "R8 lamps unchanged while discarding", led_n, led_exp);
        idle(GAP + 4 * BIT);
        lamp_frame(8'h04, 1'b0);
        led_exp = 3'b011;
        check(ok_cnt == ok0 + 1 && led_n == led_exp, "R8 accepts after quiet", led_n, led_exp);

        // R8 zero count
        ok0 = ok_cnt; er0 = err_cnt;
        send_byte(8'hA1, 1'b1);
        send_byte(8'h00, 1'b1);
        lamp_frame(8'h01, 1'b0);
        check(err_cnt == er0 + 1 && ok_cnt == ok0, "R8 zero count", err_cnt - er0, 1);
        idle(GAP + 4 * BIT);

        // R8 lamp count other than 2
        ok0 = ok_cnt; er0 = err_cnt;
        pay.delete(); pay.push_back(8'h01); pay.push_back(8'h01);
        send_frame(8'hA4, 8'd3, 1'b0);
        check(err_cnt == er0 + 1 && ok_cnt == ok0 && led_n == led_exp, "R8 lamp count 3", err_cnt - er0, 1);
        idle(GAP + 4 * BIT);

        // R9 timeout inside frame
        ok0 = ok_cnt; er0 = err_cnt;
        send_byte(8'hA4, 1'b1);
        send_byte(8'h02, 1'b1);
        idle(GAP + 4 * BIT);
        check(err_cnt == er0 + 1, "R9 gap timeout", err_cnt - er0, 1);
        lamp_frame(8'h03, 1'b0);
        led_exp = 3'b100;
        check(ok_cnt == ok0 + 1 && led_n == led_exp, "R9 recovers to kind", led_n, led_exp);

        // R3 stop-bit fault aborts
        ok0 = ok_cnt; er0 = err_cnt;
        send_byte(8'hA1, 1'b1);
        send_byte(8'h48, 1'b0);
        idle(4 * BIT);
        check(err_cnt == er0 + 1 && ok_cnt == ok0, "R3 framing abort", err_cnt - er0, 1);
        lamp_frame(8'h00, 1'b0);
        led_exp = 3'b111;
        check(ok_cnt == ok0 + 1 && led_n == led_exp, "R3 next frame fresh", led_n, led_exp);

        // R2 short glitch ignored, LSB-first decode
        ok0 = ok_cnt; er0 = err_cnt;
        @(negedge clk); rx = 1'b0;
        idle(3 * TICK_DIV);
        rx = 1'b1;
        idle(2 * BIT);
        check(ok_cnt == ok0 && err_cnt == er0, "R2 glitch ignored", err_cnt - er0, 0);
        chars.delete();
        pay.delete(); pay.push_back(8'h81);
        send_frame(8'hA1, 8'd2, 1'b0);
        check(chars.size() == 1 && chars[0] == 8'h81, "R2 LSB-first byte", chars.size() > 0 ? chars[0] : -1, 8'h81);

        // R7 empty line
        ok0 = ok_cnt; chars.delete();
        pay.delete();
        send_frame(8'hA1, 8'd1, 1'b0);
        check(ok_cnt == ok0 + 1 && chars.size() == 0, "R7 empty line", chars.size(), 0);

        // R7 full line, R8 over-long line
        ok0 = ok_cnt; chars.delete(); last_idx = -1;
        pay.delete();
        for (int i = 0; i < LINE; i++) pay.push_back(8'(8'h41 + i));
        send_frame(8'hA1, 8'(LINE + 1), 1'b0);
        check(ok_cnt == ok0 + 1 && chars.size() == LINE, "R7 full line count", chars.size(), LINE);
        if (chars.size() == LINE)
            check(chars[LINE-1] == 8'(8'h41 + LINE - 1) && last_idx == LINE - 1,
                  "R7 full line tail", chars[LINE-1], 8'h41 + LINE - 1);
        er0 = err_cnt; chars.delete();
        pay.push_back(8'h7A);
        send_frame(8'hA1, 8'(LINE + 2), 1'b0);
        check(err_cnt == er0 + 1 && chars.size() == 0, "R8 over-long line", err_cnt - er0, 1);
        idle(GAP + 4 * BIT);

        check(led_n == led_exp, "R10 final lamps", led_n, led_exp);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule